// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is an 8-bit register that a CPU reads and writes to steer interrupts. It holds five enable bits and three event flags. The five enables are a master enable, an enable for the peripheral group and one enable for each of three local sources. The three local sources are a timer overflow pulse, an external event pulse and a change detector on four port pins. Each flag records its event whether or not the matching enable is set. A single request line is raised when the master enable is on and at least one enabled source, or the enabled peripheral group, is pending.

The port-change detector works on the four pins after a two-flop synchronizer. It compares them with a snapshot that is reloaded every time the CPU reads the port. While the synchronized pins differ from that snapshot, the detector sets its flag again on every cycle, so clearing the flag in software does not hold. Software first reads the port, which refreshes the snapshot, and then clears the flag. Only software writes clear a flag.

Top module: `irq_ctrl_reg`

## Requirements
- R1: After reset, register bits 7 down to 1 read as 0 and the request output is 0. The reset value of bit 0 is left unspecified.
- R2: The register layout, from bit 7 down to bit 0, is: master enable, peripheral-group enable, timer enable, external enable, port-change enable, timer flag, external flag, port-change flag. A write with `sel` and `wr_en` high loads all eight bits from `wdata`. With `sel` high, `rdata` returns the register one cycle after the write.
- R3: A `tmr_ovf` or `ext_evt` pulse sets bit 2 or bit 1 on the next clock, whatever the enable bits hold.
- R4: A set flag stays set until a register write puts 0 into that bit. Hardware never clears a flag.
- R5: If a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R6: While bit 7 is 0, `irq` is 0, whatever the other bits and `periph_req` hold.
- R7: While bit 7 is 1, `irq` is the OR of (bit 5 AND bit 2), (bit 4 AND bit 1), (bit 3 AND bit 0) and (bit 6 AND `periph_req`). `irq` is combinational from the register and `periph_req`.
- R8: `periph_req` reaches `irq` only while bit 6 and bit 7 are both 1.
- R9: A change on `port_pins` that makes them differ from the snapshot sets bit 0 on the third rising clock edge after the change. Two of those edges are spent in the synchronizer.
- R10: While the synchronized pins differ from the snapshot, bit 0 is set again on every cycle, so a write of 0 does not hold. A `port_rd` pulse loads the synchronized pins into the snapshot. After that, a write of 0 clears bit 0 and the bit stays clear.
- R11: With `sel` low, a write has no effect on the register and `rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, effective when sel is high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when sel is low |
| tmr_ovf | input | 1 | Timer overflow event pulse |
| ext_evt | input | 1 | External edge event pulse |
| periph_req | input | 1 | Combined peripheral interrupt request |
| port_pins | input | 4 | Asynchronous port pins watched for change |
| port_rd | input | 1 | Pulse marking a CPU read of the port |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The hardest state to reach is a write of 0 to the port-change flag that lands while a pin mismatch is still active. The bench has to hold the pins away from the snapshot long enough for the change to pass the synchronizer. It then clears the flag, sees the flag come back, pulses the port read and clears the flag again. The same-cycle collision between a hardware set and a software clear also needs care, so the bench drives the event pulse and the clearing write on the same clock edge. A behavioural model keeps the delayed pins in a queue and predicts `rdata` and `irq` on every cycle. A random phase then mixes writes, events, port reads and pin changes.

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr_en,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic            tmr_ovf,
  input  logic            ext_evt,
  input  logic            periph_req,
  input  logic [PINS-1:0] port_pins,
  input  logic            port_rd,
  output logic            irq
);
  localparam int B_GIE  = 7;
  localparam int B_PEN  = 6;
  localparam int B_TEN  = 5;
  localparam int B_XEN  = 4;
  localparam int B_CEN  = 3;
  localparam int B_TFL  = 2;
  localparam int B_XFL  = 1;
  localparam int B_CFL  = 0;

  logic [7:0]      ctl;
  logic [PINS-1:0] sync1, sync2, snap;

  wire wr   = sel & wr_en;
  wire mism = |(sync2 ^ snap);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      snap  <= '0;
    end else begin
      sync1 <= port_pins;
      sync2 <= sync1;
      if (port_rd) snap <= sync2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl <= '0;
    else begin
      if (wr) ctl[B_GIE:B_CEN] <= wdata[B_GIE:B_CEN];
      ctl[B_TFL] <= tmr_ovf | (wr ? wdata[B_TFL] : ctl[B_TFL]);
      ctl[B_XFL] <= ext_evt | (wr ? wdata[B_XFL] : ctl[B_XFL]);
      ctl[B_CFL] <= mism    | (wr ? wdata[B_CFL] : ctl[B_CFL]);
    end

  assign rdata = sel ? ctl : 8'h00;

  assign irq = ctl[B_GIE] & ((ctl[B_TEN] & ctl[B_TFL]) |
                             (ctl[B_XEN] & ctl[B_XFL]) |
                             (ctl[B_CEN] & ctl[B_CFL]) |
                             (ctl[B_PEN] & periph_req));
endmodule

// File: rtl/irq_ctrl_reg_chk.sv
module irq_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       tmr_ovf,
  input logic       ext_evt,
  input logic       periph_req,
  input logic       irq,
  input logic [7:0] ctl
);
  assert_tmr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ctl[2]);
  assert_ext_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> ctl[1]);
  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[2] && !(sel && wr_en)) |=> ctl[2]);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt && sel && wr_en && !wdata[1]) |=> ctl[1]);
  assert_gie_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl[7] |-> !irq);
  assert_periph_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[7] && ctl[6] && periph_req) |-> irq);
  assert_unsel_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr_en) |=> $stable(ctl[7:3]));
endmodule

bind irq_ctrl_reg irq_ctrl_reg_chk u_chk (.*);

// File: tb/irq_ctrl_reg_bench.sv
`timescale 1ns/1ps
module irq_ctrl_reg_bench;
  logic       clk = 0, rst_n = 0;
  logic       sel = 0, wr_en = 0, tmr_ovf = 0, ext_evt = 0, periph_req = 0, port_rd = 0;
  logic [7:0] wdata = 0;
  logic [3:0] port_pins = 0;
  logic [7:0] rdata;
  logic       irq;

  irq_ctrl_reg u_irq_ctrl_reg (.clk, .rst_n, .sel, .wr_en, .wdata, .rdata,
    .tmr_ovf, .ext_evt, .periph_req, .port_pins, .port_rd, .irq);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit finished = 0;
  string tag = "R1";

  logic [3:0] pipe[$];
  logic [3:0] m_snap, m_cmp;
  logic [7:0] m_reg, nxt;
  bit known;

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe = '{4'h0, 4'h0};
      m_snap = 0; m_reg = 0; known = 0;
    end else begin
      m_cmp = pipe[0];
      nxt = m_reg;
      if (sel && wr_en) begin nxt = wdata; known = 1; end
      if (tmr_ovf) nxt[2] = 1'b1;
      if (ext_evt) nxt[1] = 1'b1;
      if (m_cmp != m_snap) nxt[0] = 1'b1;
      if (port_rd) m_snap = m_cmp;
      m_reg = nxt;
      pipe.push_back(port_pins);
      void'(pipe.pop_front());
    end
  end

  function automatic logic exp_irq();
    return m_reg[7] & ((m_reg[5] & m_reg[2]) | (m_reg[4] & m_reg[1]) |
                       (m_reg[3] & m_reg[0]) | (m_reg[6] & periph_req));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] mask, er;
    mask = known ? 8'hFF : 8'hFE;
    er = sel ? m_reg : 8'h00;
    chk(tag, rdata & mask, er & mask);
    chk(tag, {7'd0, irq}, {7'd0, exp_irq()});
  endtask

  task automatic idle();
    sel = 1; wr_en = 0; tmr_ovf = 0; ext_evt = 0; port_rd = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [7:0] v);
    idle(); wr_en = 1; wdata = v;
    step(); idle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; sel = 1;
    @(negedge clk);
    chk("R1", rdata & 8'hFE, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);

    tag = "R2";
    wr(8'hF8); step();
    chk("R2", rdata, 8'hF8);
    wr(8'h50); step();
    chk("R2", rdata, 8'h50);
    wr(8'h00);

    tag = "R3";
    tmr_ovf = 1; ext_evt = 1; step(); idle();
    chk("R3", rdata & 8'h06, 8'h06);
    tag = "R6";
    chk("R6", {7'd0, irq}, 8'h00);
    tag = "R7";
    wr(8'h86);
    chk("R7", {7'd0, irq}, 8'h00);
    wr(8'hA6);
    chk("R7", {7'd0, irq}, 8'h01);
    wr(8'h96);
    chk("R7", {7'd0, irq}, 8'h01);
    wr(8'h16);
    chk("R6", {7'd0, irq}, 8'h00);

    tag = "R4";
    repeat (5) step();
    chk("R4", rdata & 8'h06, 8'h06);
    wr(8'h02);
    chk("R4", rdata & 8'h06, 8'h02);
    wr(8'h00);
    chk("R4", rdata & 8'h06, 8'h00);

    tag = "R5";
    idle(); wr_en = 1; wdata = 8'h00; ext_evt = 1; step(); idle();
    chk("R5", rdata & 8'h02, 8'h02);
    wr(8'h00);

    tag = "R8";
    periph_req = 1;
    wr(8'h80);
    chk("R8", {7'd0, irq}, 8'h00);
    wr(8'hC0);
    chk("R8", {7'd0, irq}, 8'h01);
    wr(8'h40);
    chk("R8", {7'd0, irq}, 8'h00);
    periph_req = 0;
    wr(8'h00);

    tag = "R9";
    port_pins = 4'b0101;
    step(); chk("R9", rdata & 8'h01, 8'h00);
    step(); chk("R9", rdata & 8'h01, 8'h00);
    step(); chk("R9", rdata & 8'h01, 8'h01);

    tag = "R10";
    wr(8'h00);
    chk("R10", rdata & 8'h01, 8'h01);
    port_rd = 1; step(); idle();
    wr(8'h00);
    chk("R10", rdata & 8'h01, 8'h00);
    repeat (3) step();
    chk("R10", rdata & 8'h01, 8'h00);

    tag = "R11";
    idle(); sel = 0; wr_en = 1; wdata = 8'hFF; step();
    chk("R11", rdata, 8'h00);
    idle(); step();
    chk("R11", rdata, 8'h00);

    tag = "R7";
    for (int i = 0; i < 400; i++) begin
      sel = ($urandom % 8) != 0;
      wr_en = ($urandom % 4) == 0;
      wdata = 8'($urandom);
      tmr_ovf = ($urandom % 6) == 0;
      ext_evt = ($urandom % 6) == 0;
      periph_req = $urandom % 2;
      port_rd = ($urandom % 5) == 0;
      if (($urandom % 7) == 0) port_pins = 4'($urandom);
      step();
    end
    summary();
  end
endmodule